// File: doc/BRIEF.md
# Prioritized Interrupt Controller With Vector

This block gathers eight external interrupt pins and eight internal interrupt levels into one ordered set of sixteen request slots. Each cycle it captures the live state of every source into a pending register. It qualifies that register with a software-written enable mask and picks the lowest-numbered slot that is both pending and enabled. The result goes to the processor as a single request line and as a byte code that identifies the winning slot.

Pins and levels alternate in the priority order: slot 2n is pin n and slot 2n+1 is level n. Handler software reads the byte code and adds it to the base address of a table of 4-byte handler entries. Pending bits are not cleared by reading them. A request goes away only when its source stops driving it. A global enable input gates the request line, and the byte code follows the priority result whatever the enable does.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Slot 2n is pin n and slot 2n+1 is level n, for n from 0 to 7. Slot k appears in register bit 31-k, so bit 0 is the MSB. In the pending word, bits 16 to 31 under that numbering (word[15:0]) read as zero.
- R2: The pending register is a copy of the source inputs, taken one clock after they are sampled. Reading it does not clear it. A slot stops being pending one clock after its source negates.
- R3: The mask register is at address 1 and is written through reg_we_i. Slot k is enabled when word bit 31-k is 1. word[15:0] reads as zero, and any value written there is dropped.
- R4: Among the pending slots that are enabled, the one with the lowest slot number wins.
- R5: The vector byte equals the winning slot number times 4. It is registered, so it reflects the pending and mask state one clock earlier. It reads at address 2 in word[7:0]. The pending word reads at address 0.
- R6: When no enabled slot is pending, vec_o holds 0xFF and irq_o is low.
- R7: irq_o is high only while gie_i is high and an enabled request is registered. gie_i does not affect vec_o.
- R8: After reset, the pending and mask registers are zero, vec_o is 0xFF and irq_o is low.
- R9: A mask of 0x40000000 enables only level 0, which is slot 1 and gives vector 0x04. Level 4 maps to slot 9, which gives vector 0x24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_pin_i | input | 8 | External interrupt pins, active high |
| irq_lvl_i | input | 8 | Internal interrupt levels, active high |
| gie_i | input | 1 | Global interrupt enable from the processor |
| reg_addr_i | input | 2 | Register select: 0 pending, 1 mask, 2 vector |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Registered vector code |

## Verification
A wrong capture or a wrong interleave shows up in the pending word at the next clock. It also appears one clock after that as a vector that points at the wrong slot. A fault in the priority or masking logic produces a vector that names a slot that is not eligible, or a slot that has an eligible lower-numbered slot. It can also produce 0xFF or a request while an enabled source is pending. Every such fault is visible at vec_o two clocks after the source changes, and one clock after a mask write.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [1:0] {
    ADDR_PEND = 2'd0,
    ADDR_MASK = 2'd1,
    ADDR_VEC  = 2'd2
  } reg_addr_e;

  localparam int unsigned REG_W    = 32;
  localparam int unsigned VEC_W    = 8;
  localparam logic [7:0]  IDLE_VEC = 8'hFF;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int unsigned NUM_PINS  = 8,
  localparam int unsigned NUM_SLOTS = 2 * NUM_PINS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PINS-1:0]  pin_i,
  input  logic [NUM_PINS-1:0]  lvl_i,
  output logic [NUM_SLOTS-1:0] pend_o
);
  logic [NUM_SLOTS-1:0] slots;

  // even slot = pin, odd slot = level
  for (genvar n = 0; n < NUM_PINS; n++) begin : g_ilv
    assign slots[2*n]   = pin_i[n];
    assign slots[2*n+1] = lvl_i[n];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= slots;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned NUM_SLOTS = 16,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] elig_i,
  output logic                 any_o,
  output logic [SLOT_W-1:0]    idx_o
);
  always_comb begin
    idx_o = '0;
    // scan downward so the lowest set slot is the last assignment
    for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
      if (elig_i[k]) idx_o = SLOT_W'(k);
    end
  end

  assign any_o = |elig_i;
endmodule

// File: rtl/irq_vec_reg.sv
module irq_vec_reg #(
  parameter int unsigned SLOT_W = 4,
  parameter int unsigned VEC_W  = 8,
  parameter logic [VEC_W-1:0] IDLE = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              any_i,
  input  logic [SLOT_W-1:0] idx_i,
  output logic              req_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [VEC_W-1:0] vec_d;

  assign vec_d = any_i ? (VEC_W'(idx_i) << 2) : IDLE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o <= 1'b0;
      vec_o <= IDLE;
    end else begin
      req_o <= any_i;
      vec_o <= vec_d;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 8,
  localparam int unsigned NUM_SLOTS = 2 * NUM_PINS,
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] irq_pin_i,
  input  logic [NUM_PINS-1:0] irq_lvl_i,
  input  logic                gie_i,
  input  logic [1:0]          reg_addr_i,
  input  logic                reg_we_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  output logic [REG_W-1:0]    reg_rdata_o,
  output logic                irq_o,
  output logic [VEC_W-1:0]    vec_o
);
  logic [NUM_SLOTS-1:0] pend_q;
  logic [NUM_SLOTS-1:0] mask_q;
  logic [NUM_SLOTS-1:0] elig;
  logic [REG_W-1:0]     pend_word, mask_word;
  logic [SLOT_W-1:0]    win_idx;
  logic                 win_any;
  logic                 req_q;

  irq_capture #(.NUM_PINS(NUM_PINS)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (irq_pin_i),
    .lvl_i  (irq_lvl_i),
    .pend_o (pend_q)
  );

  // mask: slot k lives at word bit REG_W-1-k
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (reg_we_i && reg_addr_i == ADDR_MASK) begin
      for (int k = 0; k < NUM_SLOTS; k++) mask_q[k] <= reg_wdata_i[REG_W-1-k];
    end
  end

  always_comb begin
    pend_word = '0;
    mask_word = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      pend_word[REG_W-1-k] = pend_q[k];
      mask_word[REG_W-1-k] = mask_q[k];
    end
  end

  assign elig = pend_q & mask_q;

  irq_prio_enc #(.NUM_SLOTS(NUM_SLOTS)) u_enc (
    .elig_i (elig),
    .any_o  (win_any),
    .idx_o  (win_idx)
  );

  irq_vec_reg #(.SLOT_W(SLOT_W), .VEC_W(VEC_W), .IDLE(IDLE_VEC)) u_vec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .any_i  (win_any),
    .idx_i  (win_idx),
    .req_o  (req_q),
    .vec_o  (vec_o)
  );

  assign irq_o = req_q & gie_i;

  always_comb begin
    unique case (reg_addr_i)
      ADDR_PEND: reg_rdata_o = pend_word;
      ADDR_MASK: reg_rdata_o = mask_word;
      ADDR_VEC:  reg_rdata_o = {{(REG_W-VEC_W){1'b0}}, vec_o};
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
  parameter int unsigned NUM_PINS  = 8,
  localparam int unsigned NUM_SLOTS = 2 * NUM_PINS,
  localparam int unsigned SLOT_W    = $clog2(NUM_SLOTS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_PINS-1:0]  irq_pin_i,
  input logic [NUM_PINS-1:0]  irq_lvl_i,
  input logic                 gie_i,
  input logic [1:0]           reg_addr_i,
  input logic [31:0]          reg_rdata_o,
  input logic                 irq_o,
  input logic [7:0]           vec_o,
  input logic [NUM_SLOTS-1:0] pend_q,
  input logic [NUM_SLOTS-1:0] mask_q
);
  logic [NUM_SLOTS-1:0] elig_d;
  logic [NUM_SLOTS-1:0] below;
  logic [SLOT_W-1:0]    vidx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) elig_d <= '0;
    else         elig_d <= pend_q & mask_q;
  end

  assign vidx  = vec_o[SLOT_W+1:2];
  assign below = (NUM_SLOTS'(1) << vidx) - NUM_SLOTS'(1);

  // R6
  idle_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig_d == '0) |-> (vec_o == 8'hFF && !irq_o));

  // R7
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> gie_i);

  // R5
  vec_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_o != 8'hFF) |-> (vec_o[1:0] == 2'b00 && vec_o[7:SLOT_W+2] == '0));

  // R4
  vec_winner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_o != 8'hFF) |-> (elig_d[vidx] && (elig_d & below) == '0));

  // R3
  mask_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd1) |-> (reg_rdata_o[15:0] == 16'h0));

  // R2
  for (genvar n = 0; n < NUM_PINS; n++) begin : g_cap
    pend_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ##1 (pend_q[2*n] == $past(irq_pin_i[n]) && pend_q[2*n+1] == $past(irq_lvl_i[n])));
  end
endmodule

bind irq_prio_ctrl irq_prio_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_pin_i   (irq_pin_i),
  .irq_lvl_i   (irq_lvl_i),
  .gie_i       (gie_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .vec_o       (vec_o),
  .pend_q      (pend_q),
  .mask_q      (mask_q)
);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins = '0, lvls = '0;
  logic        gie = 1'b1;
  logic [1:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [7:0]  vec;
  logic [31:0] mask_m = '0;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_pin_i(pins), .irq_lvl_i(lvls),
    .gie_i(gie), .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .vec_o(vec)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pend_word(logic [7:0] p, logic [7:0] l);
    logic [31:0] w = '0;
    for (int n = 0; n < 8; n++) begin
      w[31-2*n] = p[n];
      w[30-2*n] = l[n];
    end
    return w;
  endfunction

  function automatic logic [7:0] exp_vec(logic [7:0] p, logic [7:0] l, logic [31:0] m);
    logic [31:0] e = pend_word(p, l) & m;
    for (int k = 0; k < 16; k++) if (e[31-k]) return 8'(k * 4);
    return 8'hFF;
  endfunction

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wr_mask(logic [31:0] d);
    addr = 2'd1; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    mask_m = {d[31:16], 16'h0};
  endtask

  task automatic drive(logic [7:0] p, logic [7:0] l);
    pins = p; lvls = l;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_out(string req);
    logic exp_any = exp_vec(pins, lvls, mask_m) != 8'hFF;
    chk(req, vec, exp_vec(pins, lvls, mask_m));
    chk(req, irq, exp_any & gie);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R8", vec, 8'hFF);
    chk("R8", irq, 1'b0);
    rd(2'd0, d); chk("R8", d, 32'h0);
    rd(2'd1, d); chk("R8", d, 32'h0);
    rd(2'd2, d); chk("R8", d, 32'hFF);
  endtask

  task automatic t_mask_rw;
    logic [31:0] d;
    wr_mask(32'hFFFF_FFFF);
    rd(2'd1, d); chk("R3", d, 32'hFFFF_0000);
    wr_mask(32'h1234_ABCD);
    rd(2'd1, d); chk("R3", d, 32'h1234_0000);
    wr_mask(32'hFFFF_0000);
  endtask

  task automatic t_interleave;
    logic [31:0] d;
    drive(8'h00, 8'h01);
    rd(2'd0, d); chk("R1", d, 32'h4000_0000);
    chk("R1", vec, 8'h04);
    drive(8'h08, 8'h00);
    rd(2'd0, d); chk("R1", d, 32'h0200_0000);
    chk("R5", vec, 8'h18);
    drive(8'h00, 8'h10);
    chk("R9", vec, 8'h24);
    rd(2'd2, d); chk("R5", d, 32'h24);
    drive(8'hFF, 8'hFF);
    rd(2'd0, d); chk("R1", d, 32'hFFFF_0000);
  endtask

  task automatic t_priority;
    drive(8'h02, 8'h81);
    chk("R4", vec, 8'h04); check_out("R4");
    drive(8'h02, 8'h80);
    chk("R4", vec, 8'h08);
    drive(8'h00, 8'h80);
    chk("R4", vec, 8'h3C);
    drive(8'hFF, 8'hFF);
    chk("R4", vec, 8'h00);
  endtask

  task automatic t_latency;
    drive(8'h00, 8'h00);
    chk("R6", vec, 8'hFF); chk("R6", irq, 1'b0);
    pins = 8'h40;
    @(negedge clk);
    chk("R5", vec, 8'hFF);
    @(negedge clk);
    chk("R5", vec, 8'h30);
    pins = 8'h00;
    @(negedge clk);
    chk("R2", vec, 8'h30);
    @(negedge clk);
    chk("R2", vec, 8'hFF);
  endtask

  task automatic t_masking;
    wr_mask(32'h4000_0000);
    drive(8'h01, 8'h00);
    chk("R6", vec, 8'hFF); chk("R6", irq, 1'b0);
    drive(8'h01, 8'h01);
    chk("R9", vec, 8'h04); chk("R9", irq, 1'b1);
    drive(8'h01, 8'h10);
    chk("R9", vec, 8'hFF);
    wr_mask(32'hFFFF_0000);
  endtask

  task automatic t_gie;
    drive(8'h00, 8'h04);
    gie = 1'b0; #1;
    chk("R7", irq, 1'b0); chk("R7", vec, 8'h14);
    gie = 1'b1; #1;
    chk("R7", irq, 1'b1);
  endtask

  task automatic t_read_keep;
    logic [31:0] d1, d2;
    drive(8'h20, 8'h00);
    rd(2'd0, d1);
    @(negedge clk);
    rd(2'd0, d2);
    chk("R2", d2, d1);
    chk("R2", d2, 32'h0020_0000 << 0 | pend_word(8'h20, 8'h00));
    chk("R2", vec, 8'h28);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_mask_rw();
    t_interleave();
    t_priority();
    t_latency();
    t_masking();
    t_gie();
    t_read_keep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule